// File: doc/BRIEF.md
# USB Dual-Role Status Monitor

This block keeps the status word that the glue logic around a USB dual-role controller exposes to software. The USB core reports two kinds of event to it, each as a one-cycle strobe carrying a level qualifier. A VBUS event gives the new level of the VBUS-valid indication. A session event marks the start of a session (level 1) or its end (level 0). The block applies these events to its status bits and keeps the session-valid and session-end flags mutually exclusive. When a VBUS event actually changes the stored VBUS-valid value, the block sends a one-cycle change request to the top-level interrupt block.

The remaining status fields come from plain inputs that are sampled every clock: power/clock good, VBUS sense, the ID role indication (0 means host role) and the two-bit line state. The bus sees the word through a registered read port. The VBUS-valid bit is masked to zero in that view unless the VBUS detect enable bit of the power-management word is set. Bus writes have no effect on anything.

Top module: `otg_status_mon`

## Requirements
- R1: After reset, a read returns 0 and the change request output is low.
- R2: A VBUS event (`vbus_evt`=1) copies `vbus_lvl` into status bit 5 (VBUS valid) at the next clock edge.
- R3: When a VBUS event brings a level that differs from the stored bit 5, `vbus_chg_irq` is high for exactly the one cycle that follows the event's clock edge.
- R4: A VBUS event whose level equals the stored bit 5 does not raise `vbus_chg_irq`, and neither does a session event.
- R5: A session event with level 1 sets bit 6 (session valid) and clears bit 7 (session end). With level 0 it clears bit 6 and sets bit 7. Bits 6 and 7 are never both 1.
- R6: In the read view, bit 5 reads 0 whenever bit 9 of `pm_word` (VBUS detect enable) is 0. The stored value is kept and shows again once the enable is set. No other bit is affected.
- R7: Each clock samples `pwr_good` into bit 8, `vbus_sense` into bit 4, `id_stat` into bit 3 and `line_st` into bits 1:0. Bit 2 and bits 9 and above always read 0.
- R8: A VBUS event and a session event in the same cycle are both applied at that edge.
- R9: Bus writes (`bus_wr`, `bus_wdata`) change no status bit and raise no change request.
- R10: `bus_rdata` is loaded with the filtered status word at the clock edge where `bus_rd` is 1. It holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbus_evt | input | 1 | VBUS level event strobe |
| vbus_lvl | input | 1 | New VBUS-valid level for the event |
| sess_evt | input | 1 | Session event strobe |
| sess_lvl | input | 1 | 1 = session begins, 0 = session ends |
| pwr_good | input | 1 | Power/clock good indication |
| vbus_sense | input | 1 | VBUS sense indication |
| id_stat | input | 1 | Role indication, 0 = host |
| line_st | input | 2 | Bus line state |
| pm_word | input | 32 | Power-management word; bit 9 enables VBUS detection |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored) |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Registered read data |
| vbus_chg_irq | output | 1 | One-cycle VBUS change request |

## Verification
Some properties are checked by assertions on every cycle. Bits 6 and 7 are never both set. A change request only follows a VBUS event that actually moved the stored bit. A session event drives the two session flags to the pattern set by its level. Reads with detection disabled never show bit 5, and read data holds when no read is made. Other behaviour needs the bench's directed scenarios: the reset value of the whole word, the exact cycle of the request pulse, the sampled pin fields, a masked bit coming back after the enable is set, simultaneous events, and writes having no effect. These rely on a sequence of reads and on expected words that only the bench knows.

// File: rtl/otg_stat_pkg.sv
package otg_stat_pkg;
   localparam int unsigned LINE_LO   = 0;
   localparam int unsigned LINE_W    = 2;
   localparam int unsigned ID_BIT    = 3;
   localparam int unsigned SENSE_BIT = 4;
   localparam int unsigned VBUS_BIT  = 5;
   localparam int unsigned SVAL_BIT  = 6;
   localparam int unsigned SEND_BIT  = 7;
   localparam int unsigned PGOOD_BIT = 8;
   localparam int unsigned MIN_W     = PGOOD_BIT + 1;

   typedef struct packed {
      logic vld;
      logic lvl;
   } otg_evt_t;

   typedef struct packed {
      logic             pgood;
      logic             send;
      logic             sval;
      logic             vbus;
      logic             sense;
      logic             id;
      logic [LINE_W-1:0] line;
   } otg_fields_t;
endpackage

// File: rtl/otg_vbus_track.sv
module otg_vbus_track
   import otg_stat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  otg_evt_t evt,
   output logic     vbus_q,
   output logic     chg_pulse
);
   logic differs;
   assign differs = evt.vld && (evt.lvl != vbus_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbus_q    <= 1'b0;
         chg_pulse <= 1'b0;
      end else begin
         chg_pulse <= differs;
         if (evt.vld) vbus_q <= evt.lvl;
      end
   end

   // R3: a request only follows an event that moved the stored bit
   p_pulse_on_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |-> ($past(evt.vld) && (vbus_q != $past(vbus_q))));
   // R4: a repeated level raises nothing
   p_no_pulse_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.vld && (evt.lvl == vbus_q)) |=> !chg_pulse);
   // R2: the event level lands in the stored bit
   p_level_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt.vld |=> (vbus_q == $past(evt.lvl)));
endmodule

// File: rtl/otg_sess_track.sv
module otg_sess_track
   import otg_stat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  otg_evt_t evt,
   output logic     sess_valid,
   output logic     sess_end
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sess_valid <= 1'b0;
         sess_end   <= 1'b0;
      end else if (evt.vld) begin
         sess_valid <= evt.lvl;
         sess_end   <= !evt.lvl;
      end
   end

   // R5: the two session flags never coexist
   p_sess_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sess_valid, sess_end}));
   // R5: an event drives the flag pair to the pattern given by its level
   p_sess_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt.vld |=> (sess_valid == $past(evt.lvl)) && (sess_end != $past(evt.lvl)));
endmodule

// File: rtl/otg_pin_sample.sv
module otg_pin_sample
   import otg_stat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              vbus_sense,
   input  logic              id_stat,
   input  logic [LINE_W-1:0] line_st,
   output logic              pgood_q,
   output logic              sense_q,
   output logic              id_q,
   output logic [LINE_W-1:0] line_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgood_q <= 1'b0;
         sense_q <= 1'b0;
         id_q    <= 1'b0;
         line_q  <= '0;
      end else begin
         pgood_q <= pwr_good;
         sense_q <= vbus_sense;
         id_q    <= id_stat;
         line_q  <= line_st;
      end
   end

   // R7: sampled fields track their pins one edge later
   p_pins_sampled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (line_q == $past(line_st)) && (id_q == $past(id_stat)));
endmodule

// File: rtl/otg_read_view.sv
module otg_read_view
   import otg_stat_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MGMT_W     = 32,
   parameter int unsigned DET_EN_BIT = 9,
   parameter bit          REG_READ   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  otg_fields_t       fields,
   input  logic [MGMT_W-1:0] mgmt,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned FW = $bits(otg_fields_t);
   localparam int unsigned PAD_W = DATA_W - MIN_W;

   initial begin
      assert (DATA_W >= MIN_W) else $error("read width too small");
      assert (DET_EN_BIT < MGMT_W) else $error("enable bit outside word");
      assert (FW == MIN_W - 1) else $error("field layout mismatch");
   end

   otg_fields_t shown;
   logic [DATA_W-1:0] word;

   always_comb begin
      shown = fields;
      if (!mgmt[DET_EN_BIT]) shown.vbus = 1'b0;
   end

   // bit 2 is a reserved zero slot between ID and line state
   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {{PAD_W{1'b0}}, shown.pgood, shown.send, shown.sval,
                        shown.vbus, shown.sense, shown.id, 1'b0, shown.line};
      end else begin : g_nopad
         assign word = {shown.pgood, shown.send, shown.sval,
                        shown.vbus, shown.sense, shown.id, 1'b0, shown.line};
      end

      if (REG_READ) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  rdata <= '0;
            else if (rd) rdata <= word;
         end
         // R10: no read, no change
         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd |=> $stable(rdata));
         // R6: detection disabled hides the VBUS bit
         p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !mgmt[DET_EN_BIT]) |=> !rdata[VBUS_BIT]);
      end else begin : g_comb
         assign rdata = rd ? word : '0;
      end
   endgenerate
endmodule

// File: rtl/otg_status_mon.sv
module otg_status_mon
   import otg_stat_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MGMT_W     = 32,
   parameter int unsigned DET_EN_BIT = 9,
   parameter bit          REG_READ   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vbus_evt,
   input  logic                     vbus_lvl,
   input  logic                     sess_evt,
   input  logic                     sess_lvl,
   input  logic                     pwr_good,
   input  logic                     vbus_sense,
   input  logic                     id_stat,
   input  logic [1:0]               line_st,
   input  logic [MGMT_W-1:0]        pm_word,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     vbus_chg_irq
);
   initial begin
      assert (LINE_W == 2) else $error("line state width mismatch");
   end

   otg_evt_t    vbus_e, sess_e;
   otg_fields_t fld;
   logic        unused_wr_bits;

   assign vbus_e = '{vld: vbus_evt, lvl: vbus_lvl};
   assign sess_e = '{vld: sess_evt, lvl: sess_lvl};
   // the status word is read-only; write traffic is deliberately dropped
   assign unused_wr_bits = ^{bus_wr, bus_wdata};

   otg_vbus_track u_vbus (
      .clk(clk), .rst_n(rst_n), .evt(vbus_e),
      .vbus_q(fld.vbus), .chg_pulse(vbus_chg_irq)
   );

   otg_sess_track u_sess (
      .clk(clk), .rst_n(rst_n), .evt(sess_e),
      .sess_valid(fld.sval), .sess_end(fld.send)
   );

   otg_pin_sample u_pins (
      .clk(clk), .rst_n(rst_n),
      .pwr_good(pwr_good), .vbus_sense(vbus_sense),
      .id_stat(id_stat), .line_st(line_st),
      .pgood_q(fld.pgood), .sense_q(fld.sense),
      .id_q(fld.id), .line_q(fld.line)
   );

   otg_read_view #(
      .DATA_W(DATA_W), .MGMT_W(MGMT_W),
      .DET_EN_BIT(DET_EN_BIT), .REG_READ(REG_READ)
   ) u_view (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd),
      .fields(fld), .mgmt(pm_word), .rdata(bus_rdata)
   );

   // R9: a write alone leaves the event-driven bits untouched
   p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !vbus_evt && !sess_evt) |=>
         ($stable(fld.vbus) && $stable(fld.sval) && $stable(fld.send) && !vbus_chg_irq));
   // R8: joint events land together
   p_joint_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vbus_evt && sess_evt) |=> (fld.vbus == $past(vbus_lvl)) && (fld.sval == $past(sess_lvl)));
endmodule

// File: tb/otg_status_mon_test.sv
module otg_status_mon_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vbus_evt = 0, vbus_lvl = 0, sess_evt = 0, sess_lvl = 0;
   logic        pwr_good = 0, vbus_sense = 0, id_stat = 0;
   logic [1:0]  line_st = 2'b00;
   logic [31:0] pm_word = 32'h0000_0200;
   logic        bus_rd = 0, bus_wr = 0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        vbus_chg_irq;
   int          total = 0, bad = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   otg_status_mon uut (
      .clk(clk), .rst_n(rst_n), .vbus_evt(vbus_evt), .vbus_lvl(vbus_lvl),
      .sess_evt(sess_evt), .sess_lvl(sess_lvl), .pwr_good(pwr_good),
      .vbus_sense(vbus_sense), .id_stat(id_stat), .line_st(line_st),
      .pm_word(pm_word), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vbus_chg_irq(vbus_chg_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_word(output logic [31:0] v);
      @(negedge clk) bus_rd = 1;
      @(negedge clk) bus_rd = 0;
      v = bus_rdata;
   endtask

   // one VBUS event; checks the request in the cycle after the edge and the one after that
   task automatic vbus_event(input logic lvl, input logic exp_irq, input string req);
      @(negedge clk) begin vbus_evt = 1; vbus_lvl = lvl; end
      @(negedge clk) vbus_evt = 0;
      chk(req, {31'b0, vbus_chg_irq}, {31'b0, exp_irq});
      @(negedge clk);
      chk(req, {31'b0, vbus_chg_irq}, 32'h0);
   endtask

   task automatic sess_event(input logic lvl);
      @(negedge clk) begin sess_evt = 1; sess_lvl = lvl; end
      @(negedge clk) sess_evt = 0;
      chk("R4", {31'b0, vbus_chg_irq}, 32'h0);
   endtask

   task automatic t_reset;
      chk("R1", {31'b0, vbus_chg_irq}, 32'h0);
      rd_word(rv);
      chk("R1", rv, 32'h0);
   endtask

   task automatic t_vbus;
      vbus_event(1'b1, 1'b1, "R3");
      rd_word(rv);
      chk("R2", rv, 32'h20);
      vbus_event(1'b1, 1'b0, "R4");
      vbus_event(1'b0, 1'b1, "R3");
      rd_word(rv);
      chk("R2", rv, 32'h0);
      vbus_event(1'b0, 1'b0, "R4");
   endtask

   task automatic t_session;
      sess_event(1'b1);
      rd_word(rv);
      chk("R5", rv, 32'h40);
      sess_event(1'b0);
      rd_word(rv);
      chk("R5", rv, 32'h80);
   endtask

   task automatic t_mask;
      vbus_event(1'b1, 1'b1, "R3");
      pm_word = 32'hFFFF_FDFF;
      rd_word(rv);
      chk("R6", rv, 32'h80);
      pm_word = 32'h0000_0200;
      rd_word(rv);
      chk("R6", rv, 32'hA0);
   endtask

   task automatic t_pins;
      @(negedge clk) begin pwr_good = 1; vbus_sense = 1; id_stat = 1; line_st = 2'b10; end
      rd_word(rv);
      chk("R7", rv, 32'h1BA);
      @(negedge clk) begin pwr_good = 0; vbus_sense = 0; id_stat = 0; line_st = 2'b01; end
      rd_word(rv);
      chk("R7", rv, 32'hA1);
      @(negedge clk) line_st = 2'b00;
   endtask

   task automatic t_joint;
      @(negedge clk) begin vbus_evt = 1; vbus_lvl = 0; sess_evt = 1; sess_lvl = 1; end
      @(negedge clk) begin vbus_evt = 0; sess_evt = 0; end
      chk("R8", {31'b0, vbus_chg_irq}, 32'h1);
      rd_word(rv);
      chk("R8", rv, 32'h40);
   endtask

   task automatic t_write;
      @(negedge clk) begin bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; end
      @(negedge clk) begin bus_wr = 0; bus_wdata = '0; end
      chk("R9", {31'b0, vbus_chg_irq}, 32'h0);
      rd_word(rv);
      chk("R9", rv, 32'h40);
   endtask

   task automatic t_hold;
      vbus_event(1'b1, 1'b1, "R3");
      @(negedge clk);
      chk("R10", bus_rdata, 32'h40);
      rd_word(rv);
      chk("R10", rv, 32'h60);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_vbus();
      t_session();
      t_mask();
      t_pins();
      t_joint();
      t_write();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule